// File: doc/BRIEF.md
# Camera Capture Sequencer with Interrupt Control

This block controls frame capture for one channel of a camera input path. Software picks one of two modes through a control register. Continuous video capture runs frame after frame. Still capture takes exactly one frame. The block itself moves no pixels. It follows the frame-start, last-pixel, field-identification and end-of-horizontal-blank strobes from the pixel path, and from them derives two capture-busy flags that change only at frame boundaries.

A software-written buffer base address is copied into a working register on every frame start. The DMA side reads this working register for the whole frame. A write that arrives after a frame start therefore only reaches the frame after it.

Seven event sources set pending flags: frame completed, overflow of each of three pixel FIFOs, a multi-channel write error, FIFO overflow persisting past horizontal blanking, and frame start. Software clears these flags by writing ones to them. Each flag has an enable bit, and a single interrupt line reports any enabled flag that is pending.

Top module: `cap_ctrl`

## Requirements
- R1: The video-busy flag (STATUS bit 0) rises on the cycle after the first vsync strobe that arrives while video enable (CONTROL bit 0) is set and neither busy flag is set. Setting video enable alone leaves it low.
- R2: Once video enable is cleared, the video-busy flag stays set until the next frame end, and then falls on the following cycle.
- R3: Writing a 1 to CONTROL bit 1 arms a still request. The still-busy flag (STATUS bit 1) rises after the next vsync, falls after the next frame end, and does not rise again on later vsyncs.
- R4: A still request written while either busy flag is set is discarded, so it starts no capture. The two busy flags are never set at the same time.
- R5: Each vsync copies the buffer address register (address 4) into the working address (address 5, output `cur_buf_addr`). A buffer write in the same cycle as a vsync, or any later write, shows up only at the following vsync.
- R6: The frame-done flag (pending bit 1) is set at every frame end that occurs while video is busy and video enable is still set. It is not set for the frame that ends after video enable has been cleared, and it is not set for still frames.
- R7: Pending bits 2, 3 and 4 are set while FIFO overflow inputs 0, 1 and 2 are high. Bit 5 is set by the multi-channel error input. Bit 7 is set by vsync.
- R8: Pending bit 6 is set only when the end-of-horizontal-blank strobe arrives while all three FIFO overflow inputs are high.
- R9: Frame end is a last-pixel strobe. When both interlaced (CONTROL bit 2) and planar 4:2:0 (CONTROL bit 3) are set, the strobe counts only when `field2` is high. Otherwise every last-pixel strobe counts.
- R10: Writing ones to the pending register (address 3) clears those bits. If a bit's event occurs in the same cycle as the clearing write, the bit stays set.
- R11: `irq` is high exactly when some pending bit is set and its enable bit (address 2, bits 7:1) is set. Enable bit 0 always reads 0. After reset all enables, pending bits, busy flags and addresses are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index (0 control, 1 status, 2 enable, 3 pending, 4 buffer address, 5 working address) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| vsync | input | 1 | Frame-start strobe |
| last_px | input | 1 | Last-pixel-of-field strobe |
| field2 | input | 1 | High when the current field is the second field |
| hblank_end | input | 1 | End-of-horizontal-blank strobe |
| fifo_ovf | input | 3 | Overflow indications of FIFOs 0 to 2 |
| mc_err | input | 1 | Multi-channel write error strobe |
| video_busy | output | 1 | Video capture in progress |
| still_busy | output | 1 | Still capture in progress |
| cur_buf_addr | output | 32 | Working buffer address for the current frame |
| irq | output | 1 | Interrupt request |

## Verification
A wrong busy or arm state shows on `video_busy`/`still_busy` one cycle after the vsync or frame-end strobe that should have moved it. The tests therefore sample one cycle after each strobe, both when a transition is expected and when one is not. An address shadow that is stale or updated early shows up on `cur_buf_addr` right after the vsync that should load it, and also in the cycles between writes and vsyncs. A wrong pending or enable bit is visible in the same cycle, both in the pending read value and on `irq`. Races between a clearing write and a new event are driven into the same clock cycle.

// File: rtl/cap_pkg.sv
package cap_pkg;
    localparam int REG_AW = 3;

    localparam logic [REG_AW-1:0] A_CTRL = 3'd0;
    localparam logic [REG_AW-1:0] A_STAT = 3'd1;
    localparam logic [REG_AW-1:0] A_IEN  = 3'd2;
    localparam logic [REG_AW-1:0] A_PEND = 3'd3;
    localparam logic [REG_AW-1:0] A_BUF  = 3'd4;
    localparam logic [REG_AW-1:0] A_ACT  = 3'd5;

    localparam int EV_W    = 8;
    localparam int EV_FD   = 1;
    localparam int EV_FIFO = 2;
    localparam int EV_MC   = 5;
    localparam int EV_HB   = 6;
    localparam int EV_VS   = 7;
    localparam logic [EV_W-1:0] EV_MASK = 8'hFE;

    typedef struct packed {
        logic vid_busy;
        logic still_busy;
        logic still_arm;
    } seq_state_t;

    typedef struct packed {
        logic [EV_W-1:0] en;
        logic [EV_W-1:0] pend;
    } irq_state_t;
endpackage

// File: rtl/cap_seq.sv
module cap_seq
    import cap_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic video_en,
    input  logic still_req,
    input  logic interlaced,
    input  logic planar420,
    input  logic vsync,
    input  logic last_px,
    input  logic field2,
    output logic vid_busy,
    output logic still_busy,
    output logic fd_evt
);
    seq_state_t state_d, state_q;
    logic frame_end;
    logic start_vid;
    logic start_still;

    always_comb begin
        state_d     = state_q;
        frame_end   = last_px && (!(interlaced && planar420) || field2);
        start_vid   = vsync && video_en && !state_q.vid_busy && !state_q.still_busy;
        start_still = vsync && state_q.still_arm && !state_q.still_busy
                      && !state_q.vid_busy && !start_vid;
        fd_evt      = state_q.vid_busy && frame_end && video_en;

        if (vsync) begin
            state_d.still_arm = 1'b0;
        end
        if (still_req && !state_q.vid_busy && !state_q.still_busy) begin
            state_d.still_arm = 1'b1;
        end

        if (start_vid) begin
            state_d.vid_busy = 1'b1;
        end else if (state_q.vid_busy && frame_end && !video_en) begin
            state_d.vid_busy = 1'b0;
        end

        if (start_still) begin
            state_d.still_busy = 1'b1;
        end else if (state_q.still_busy && frame_end) begin
            state_d.still_busy = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign vid_busy   = state_q.vid_busy;
    assign still_busy = state_q.still_busy;

    AST_VID_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q.vid_busy) |-> ($past(vsync) && $past(video_en))); // R1
    AST_VID_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(state_q.vid_busy) |-> ($past(frame_end) && !$past(video_en))); // R2
    AST_STILL_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(state_q.still_busy) |-> $past(frame_end)); // R3
    AST_BUSY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(state_q.vid_busy && state_q.still_busy)); // R4
endmodule

// File: rtl/cap_irq.sv
module cap_irq
    import cap_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [EV_W-1:0] set_vec,
    input  logic            en_wr,
    input  logic            clr_wr,
    input  logic [EV_W-1:0] wdata,
    output logic [EV_W-1:0] en,
    output logic [EV_W-1:0] pend,
    output logic            irq
);
    irq_state_t state_d, state_q;
    logic [EV_W-1:0] clr_mask;

    always_comb begin
        state_d  = state_q;
        clr_mask = clr_wr ? wdata : '0;
        if (en_wr) begin
            state_d.en = wdata & EV_MASK;
        end
        state_d.pend = ((state_q.pend & ~clr_mask) | set_vec) & EV_MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign en   = state_q.en;
    assign pend = state_q.pend;
    assign irq  = |(state_q.pend & state_q.en);

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec != '0) |=> ((state_q.pend & $past(set_vec & EV_MASK)) == $past(set_vec & EV_MASK))); // R10
    AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && set_vec == '0) |=> ((state_q.pend & $past(wdata)) == '0)); // R10
endmodule

// File: rtl/cap_ctrl.sv
module cap_ctrl
    import cap_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              vsync,
    input  logic              last_px,
    input  logic              field2,
    input  logic              hblank_end,
    input  logic [2:0]        fifo_ovf,
    input  logic              mc_err,
    output logic              video_busy,
    output logic              still_busy,
    output logic [ADDR_W-1:0] cur_buf_addr,
    output logic              irq
);
    localparam int NFIFO = 3;

    typedef struct packed {
        logic              video_en;
        logic              interlaced;
        logic              planar420;
        logic [ADDR_W-1:0] buf_addr;
        logic [ADDR_W-1:0] act_addr;
    } top_state_t;

    top_state_t state_d, state_q;
    logic            wr_ctrl;
    logic            still_req;
    logic            fd_evt;
    logic [EV_W-1:0] set_vec;
    logic [EV_W-1:0] ien;
    logic [EV_W-1:0] pend;

    always_comb begin
        state_d   = state_q;
        wr_ctrl   = reg_wr && (reg_addr == A_CTRL);
        still_req = wr_ctrl && reg_wdata[1];
        if (wr_ctrl) begin
            state_d.video_en   = reg_wdata[0];
            state_d.interlaced = reg_wdata[2];
            state_d.planar420  = reg_wdata[3];
        end
        if (reg_wr && (reg_addr == A_BUF)) begin
            state_d.buf_addr = reg_wdata[ADDR_W-1:0];
        end
        if (vsync) begin
            state_d.act_addr = state_q.buf_addr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    cap_seq i_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .video_en   (state_q.video_en),
        .still_req  (still_req),
        .interlaced (state_q.interlaced),
        .planar420  (state_q.planar420),
        .vsync      (vsync),
        .last_px    (last_px),
        .field2     (field2),
        .vid_busy   (video_busy),
        .still_busy (still_busy),
        .fd_evt     (fd_evt)
    );

    always_comb begin
        set_vec        = '0;
        set_vec[EV_FD] = fd_evt;
        for (int i = 0; i < NFIFO; i++) begin
            set_vec[EV_FIFO+i] = fifo_ovf[i];
        end
        set_vec[EV_MC] = mc_err;
        set_vec[EV_HB] = hblank_end && (&fifo_ovf);
        set_vec[EV_VS] = vsync;
    end

    cap_irq i_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_vec(set_vec),
        .en_wr  (reg_wr && (reg_addr == A_IEN)),
        .clr_wr (reg_wr && (reg_addr == A_PEND)),
        .wdata  (reg_wdata[EV_W-1:0]),
        .en     (ien),
        .pend   (pend),
        .irq    (irq)
    );

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_CTRL: begin
                reg_rdata[0] = state_q.video_en;
                reg_rdata[2] = state_q.interlaced;
                reg_rdata[3] = state_q.planar420;
            end
            A_STAT: begin
                reg_rdata[0] = video_busy;
                reg_rdata[1] = still_busy;
            end
            A_IEN:   reg_rdata[EV_W-1:0]   = ien;
            A_PEND:  reg_rdata[EV_W-1:0]   = pend;
            A_BUF:   reg_rdata[ADDR_W-1:0] = state_q.buf_addr;
            A_ACT:   reg_rdata[ADDR_W-1:0] = state_q.act_addr;
            default: reg_rdata = '0;
        endcase
    end

    assign cur_buf_addr = state_q.act_addr;

    AST_ADDR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        vsync |=> (cur_buf_addr == $past(state_q.buf_addr))); // R5
    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !vsync |=> $stable(cur_buf_addr)); // R5
    AST_HB_NEEDS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (hblank_end && !(&fifo_ovf) && !(reg_wr && reg_addr == A_PEND) && !pend[EV_HB])
        |=> !pend[EV_HB]); // R8
endmodule

// File: tb/test_cap_ctrl.sv
`timescale 1ns/1ps
module test_cap_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        vsync = 1'b0, last_px = 1'b0, field2 = 1'b0, hblank_end = 1'b0, mc_err = 1'b0;
    logic [2:0]  fifo_ovf = '0;
    logic        video_busy, still_busy, irq;
    logic [31:0] cur_buf_addr;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    cap_ctrl i_cap_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .vsync(vsync),
        .last_px(last_px), .field2(field2), .hblank_end(hblank_end),
        .fifo_ovf(fifo_ovf), .mc_err(mc_err), .video_busy(video_busy),
        .still_busy(still_busy), .cur_buf_addr(cur_buf_addr), .irq(irq)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    task automatic p_vsync();
        vsync = 1'b1; @(negedge clk); vsync = 1'b0;
    endtask

    task automatic p_last(input logic f2);
        last_px = 1'b1; field2 = f2; @(negedge clk); last_px = 1'b0; field2 = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(3'd1, v); chk("R11", "status after reset", v, 0);
        rd(3'd2, v); chk("R11", "enable after reset", v, 0);
        rd(3'd3, v); chk("R11", "pending after reset", v, 0);
        chk("R11", "irq after reset", {31'd0, irq}, 0);
        chk("R11", "working addr after reset", cur_buf_addr, 0);
    endtask

    task automatic t_video();
        logic [31:0] v;
        wr(3'd0, 32'h1);
        chk("R1", "video busy waits for vsync", {31'd0, video_busy}, 0);
        p_vsync();
        chk("R1", "video busy after vsync", {31'd0, video_busy}, 1);
        wr(3'd3, 32'hFF);
        p_last(1'b0);
        rd(3'd3, v); chk("R6", "frame done while enabled", {31'd0, v[1]}, 1);
        chk("R1", "video busy continues", {31'd0, video_busy}, 1);
        wr(3'd0, 32'h0);
        wr(3'd3, 32'hFF);
        chk("R2", "busy held after disable", {31'd0, video_busy}, 1);
        p_vsync();
        chk("R2", "busy held over vsync", {31'd0, video_busy}, 1);
        p_last(1'b0);
        chk("R2", "busy cleared at frame end", {31'd0, video_busy}, 0);
        rd(3'd3, v); chk("R6", "no frame done after disable", {31'd0, v[1]}, 0);
    endtask

    task automatic t_still();
        logic [31:0] v;
        wr(3'd3, 32'hFF);
        wr(3'd0, 32'h2);
        chk("R3", "still waits for vsync", {31'd0, still_busy}, 0);
        p_vsync();
        chk("R3", "still busy after vsync", {31'd0, still_busy}, 1);
        p_last(1'b0);
        chk("R3", "still cleared at frame end", {31'd0, still_busy}, 0);
        rd(3'd3, v); chk("R6", "no frame done for still", {31'd0, v[1]}, 0);
        p_vsync();
        chk("R3", "still single frame only", {31'd0, still_busy}, 0);
    endtask

    task automatic t_still_ignored();
        wr(3'd0, 32'h1);
        p_vsync();
        chk("R4", "video running", {31'd0, video_busy}, 1);
        wr(3'd0, 32'h3);
        wr(3'd0, 32'h0);
        p_last(1'b0);
        chk("R4", "video ended", {31'd0, video_busy}, 0);
        p_vsync();
        chk("R4", "discarded still request", {31'd0, still_busy}, 0);
    endtask

    task automatic t_addr();
        wr(3'd4, 32'h1000);
        chk("R5", "no load before vsync", cur_buf_addr, 0);
        p_vsync();
        chk("R5", "load at vsync", cur_buf_addr, 32'h1000);
        wr(3'd4, 32'h2000);
        chk("R5", "write after vsync not seen", cur_buf_addr, 32'h1000);
        p_vsync();
        chk("R5", "next vsync loads", cur_buf_addr, 32'h2000);
        reg_wr = 1'b1; reg_addr = 3'd4; reg_wdata = 32'h3000; vsync = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; vsync = 1'b0;
        chk("R5", "same-cycle write loads old", cur_buf_addr, 32'h2000);
        p_vsync();
        chk("R5", "same-cycle write at next vsync", cur_buf_addr, 32'h3000);
    endtask

    task automatic t_flags();
        logic [31:0] v;
        wr(3'd3, 32'hFF);
        fifo_ovf = 3'b010; @(negedge clk); fifo_ovf = 3'b000;
        rd(3'd3, v); chk("R7", "fifo1 overflow", v, 32'h08);
        mc_err = 1'b1; @(negedge clk); mc_err = 1'b0;
        rd(3'd3, v); chk("R7", "multi-channel error", v, 32'h28);
        p_vsync();
        rd(3'd3, v); chk("R7", "vsync flag", v, 32'hA8);
        wr(3'd3, 32'hFF);
        fifo_ovf = 3'b011; hblank_end = 1'b1; @(negedge clk);
        fifo_ovf = 3'b000; hblank_end = 1'b0;
        rd(3'd3, v); chk("R8", "hblank with two fifos", v, 32'h0C);
        wr(3'd3, 32'hFF);
        fifo_ovf = 3'b111; hblank_end = 1'b1; @(negedge clk);
        fifo_ovf = 3'b000; hblank_end = 1'b0;
        rd(3'd3, v); chk("R8", "hblank with all fifos", v, 32'h5C);
        wr(3'd3, 32'h04);
        rd(3'd3, v); chk("R10", "clear one bit", v, 32'h58);
        fifo_ovf = 3'b001;
        wr(3'd3, 32'h04);
        fifo_ovf = 3'b000;
        rd(3'd3, v); chk("R10", "set beats clear", v, 32'h5C);
        wr(3'd3, 32'hFF);
        rd(3'd3, v); chk("R10", "clear all", v, 0);
    endtask

    task automatic t_irq();
        logic [31:0] v;
        fifo_ovf = 3'b010; @(negedge clk); fifo_ovf = 3'b000;
        chk("R11", "masked irq", {31'd0, irq}, 0);
        wr(3'd2, 32'h08);
        chk("R11", "enabled irq", {31'd0, irq}, 1);
        wr(3'd2, 32'hF7);
        chk("R11", "other enables only", {31'd0, irq}, 0);
        rd(3'd2, v); chk("R11", "enable bit0 reads zero", v, 32'hF6);
        wr(3'd2, 32'hFF);
        wr(3'd3, 32'h08);
        chk("R11", "irq after clear", {31'd0, irq}, 0);
        wr(3'd2, 32'h0);
    endtask

    task automatic t_field();
        logic [31:0] v;
        wr(3'd0, 32'hD);
        p_vsync();
        chk("R9", "video busy interlaced", {31'd0, video_busy}, 1);
        wr(3'd3, 32'hFF);
        p_last(1'b0);
        rd(3'd3, v); chk("R9", "field1 end not frame end in 4:2:0", {31'd0, v[1]}, 0);
        p_last(1'b1);
        rd(3'd3, v); chk("R9", "field2 end is frame end", {31'd0, v[1]}, 1);
        wr(3'd0, 32'h5);
        wr(3'd3, 32'hFF);
        p_last(1'b0);
        rd(3'd3, v); chk("R9", "field1 end counts without 4:2:0", {31'd0, v[1]}, 1);
        wr(3'd0, 32'hC);
        p_last(1'b0);
        chk("R9", "disable waits for field2", {31'd0, video_busy}, 1);
        p_last(1'b1);
        chk("R9", "disable ends at field2", {31'd0, video_busy}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_video();
        t_still();
        t_still_ignored();
        t_addr();
        t_flags();
        t_irq();
        t_field();
        repeat (2) @(negedge clk);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule